// File: doc/BRIEF.md
# Predicated Vector Splice Unit

This block joins two vectors of equal length into one, under the control of a byte-granular predicate mask. The predicate is read at the chosen element size. The unit finds the lowest and the highest active elements of operand A. It copies that whole span of A, including any inactive elements inside it, into the bottom of the result. The result positions left above the span are filled from operand B, starting at B's element 0 and going upward.

The vector length is a build-time parameter. Element lanes are little-endian, so element 0 sits in the least significant bits. The datapath computes the result in one combinational pass and registers it once. A transaction is offered with a valid strobe, and its result comes back with a matching valid strobe one clock later.

Top module: `vsplice_unit`

## Requirements
- R1: The 2-bit size input selects the element width as 8 << size bits: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit and 3 is 64-bit. There are VLEN divided by that width elements.
- R2: The predicate has one bit per byte, so it is VLEN/8 bits wide. Element e is active when predicate bit e × (element bytes) is set. The other bits of that element's byte group have no effect on the result.
- R3: Result element 0 takes the lowest active element of operand A. Each A element from there up to and including the highest active element goes to the next result position, whether or not it is active itself.
- R4: If x elements were copied from A, result elements x through N−1 take operand B elements 0 through N−1−x, in ascending order.
- R5: When no element is active, the result equals operand B.
- R6: When every element is active, the result equals operand A.
- R7: out_valid is in_valid delayed by one clock. The result of a transaction accepted at one clock edge is present from the next edge.
- R8: A synchronous active-high reset clears out_valid and the result to zero.
- R9: When in_valid is low, the result register keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| size_code | input | 2 | Element size code |
| pred | input | VLEN/8 | Byte-granular predicate mask |
| opa | input | VLEN | Operand A, the source of the selected span |
| opb | input | VLEN | Operand B, the source of the fill |
| out_valid | output | 1 | Result is valid |
| result | output | VLEN | Spliced vector |

## Verification
The assertions assume that size_code, pred and both operands are stable and known whenever in_valid is high. Their data checks apply only to predicates whose meaning does not depend on the size: all zeros, all ones, and a single set bit at byte 0 or at the top byte with byte elements. The bench drives every input at the falling edge and holds it through the following rising edge, so each sampled transaction is well defined. It sweeps all four sizes over these predicates: zero, all ones, every single bit, and every pair of first and last bits with random gaps between them. It also runs predicates whose only set bits lie off the element boundaries.

// File: rtl/vsplice_pkg.sv
package vsplice_pkg;

   typedef enum logic [1:0] {
      ESZ_BYTE  = 2'd0,
      ESZ_HALF  = 2'd1,
      ESZ_WORD  = 2'd2,
      ESZ_DWORD = 2'd3
   } esz_e;

   // bytes per element for a size code (R1)
   function automatic int unsigned elem_bytes(input esz_e sz);
      return 32'd1 << sz;
   endfunction

endpackage

// File: rtl/vsplice_govern.sv
// Keeps only the predicate bit that governs each element (R2).
module vsplice_govern
   import vsplice_pkg::*;
#(
   parameter int NB = 32
) (
   input  logic [NB-1:0] pred,
   input  esz_e          esz,
   output logic [NB-1:0] gov
);

   for (genvar b = 0; b < NB; b++) begin : g_byte
      localparam bit AL2 = (b % 2) == 0;
      localparam bit AL4 = (b % 4) == 0;
      localparam bit AL8 = (b % 8) == 0;
      logic aligned;
      always_comb begin
         unique case (esz)
            ESZ_BYTE:  aligned = 1'b1;
            ESZ_HALF:  aligned = AL2;
            ESZ_WORD:  aligned = AL4;
            default:   aligned = AL8;
         endcase
      end
      assign gov[b] = pred[b] & aligned;
   end

endmodule

// File: rtl/vsplice_bounds.sv
// Finds the byte offset of the first active element and the span length in bytes.
module vsplice_bounds
   import vsplice_pkg::*;
#(
   parameter  int NB = 32,
   localparam int IW = $clog2(NB) + 1
) (
   input  logic [NB-1:0] gov,
   input  esz_e          esz,
   output logic [IW-1:0] first_byte,
   output logic [IW-1:0] span_bytes
);

   logic          any_act;
   logic [IW-1:0] last_byte;
   logic [IW-1:0] ebytes;

   always_comb begin
      first_byte = '0;
      for (int b = NB - 1; b >= 0; b--) begin
         if (gov[b]) first_byte = IW'(b);
      end
   end

   always_comb begin
      last_byte = '0;
      for (int b = 0; b < NB; b++) begin
         if (gov[b]) last_byte = IW'(b);
      end
   end

   assign any_act    = |gov;
   assign ebytes     = IW'(elem_bytes(esz));
   assign span_bytes = any_act ? (last_byte + ebytes - first_byte) : '0;

endmodule

// File: rtl/vsplice_bshift.sv
// Logarithmic byte shifter; direction chosen by parameter.
module vsplice_bshift #(
   parameter  int NB       = 32,
   parameter  bit SHIFT_UP = 1'b0,
   localparam int SW       = $clog2(NB) + 1,
   localparam int W        = NB * 8
) (
   input  logic [W-1:0]  din,
   input  logic [SW-1:0] amt,
   output logic [W-1:0]  dout
);

   logic [W-1:0] stage [SW+1];
   assign stage[0] = din;

   for (genvar s = 0; s < SW; s++) begin : g_stage
      localparam int SH = (8 << s) >= W ? W : (8 << s);
      logic [W-1:0] moved;
      if (SH >= W) begin : g_full
         assign moved = '0;
      end else if (SHIFT_UP) begin : g_up
         assign moved = stage[s] << SH;
      end else begin : g_down
         assign moved = stage[s] >> SH;
      end
      assign stage[s+1] = amt[s] ? moved : stage[s];
   end

   assign dout = stage[SW];

endmodule

// File: rtl/vsplice_unit.sv
module vsplice_unit
   import vsplice_pkg::*;
#(
   parameter  int VLEN = 256,
   localparam int NB   = VLEN / 8,
   localparam int IW   = $clog2(NB) + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [1:0]        size_code,
   input  logic [VLEN/8-1:0] pred,
   input  logic [VLEN-1:0]   opa,
   input  logic [VLEN-1:0]   opb,
   output logic              out_valid,
   output logic [VLEN-1:0]   result
);

   if (VLEN < 128 || VLEN > 2048 || (VLEN & (VLEN - 1)) != 0) begin : g_bad_vlen
      $error("vsplice_unit: VLEN must be a power of two in 128..2048");
   end

   esz_e          esz;
   logic [NB-1:0] gov;
   logic [IW-1:0] first_byte;
   logic [IW-1:0] span_bytes;
   logic [VLEN-1:0] a_low;
   logic [VLEN-1:0] b_high;
   logic [VLEN-1:0] merged;

   assign esz = esz_e'(size_code);

   vsplice_govern #(.NB(NB)) u_govern (
      .pred (pred),
      .esz  (esz),
      .gov  (gov)
   );

   vsplice_bounds #(.NB(NB)) u_bounds (
      .gov        (gov),
      .esz        (esz),
      .first_byte (first_byte),
      .span_bytes (span_bytes)
   );

   vsplice_bshift #(.NB(NB), .SHIFT_UP(1'b0)) u_shift_a (
      .din  (opa),
      .amt  (first_byte),
      .dout (a_low)
   );

   vsplice_bshift #(.NB(NB), .SHIFT_UP(1'b1)) u_shift_b (
      .din  (opb),
      .amt  (span_bytes),
      .dout (b_high)
   );

   for (genvar j = 0; j < NB; j++) begin : g_merge
      assign merged[j*8 +: 8] = (span_bytes > IW'(j)) ? a_low[j*8 +: 8] : b_high[j*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= merged;
      end
   end

endmodule

// File: rtl/vsplice_unit_chk.sv
module vsplice_unit_chk #(
   parameter int VLEN = 256
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [1:0]        size_code,
   input logic [VLEN/8-1:0] pred,
   input logic [VLEN-1:0]   opa,
   input logic [VLEN-1:0]   opb,
   input logic              out_valid,
   input logic [VLEN-1:0]   result
);

   localparam int NB = VLEN / 8;

   p_lat_hi_r7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   p_lat_lo_r7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   p_reset_r8: assert property (@(posedge clk)
      rst |=> (!out_valid && result == '0));

   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result));

   p_none_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && pred == '0) |=> result == $past(opb));

   p_all_r6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && pred == '1) |=> result == $past(opa));

   p_bottom_r4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && size_code == 2'd0 && pred == NB'(1))
      |=> result == {$past(opb[VLEN-9:0]), $past(opa[7:0])});

   p_top_r3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && size_code == 2'd0 && pred == {1'b1, {(NB-1){1'b0}}})
      |=> result == {$past(opb[VLEN-9:0]), $past(opa[VLEN-1 -: 8])});

endmodule

bind vsplice_unit vsplice_unit_chk #(.VLEN(VLEN)) u_chk (.*);

// File: tb/vsplice_unit_tb.sv
module vsplice_unit_tb;

   localparam int VLEN = 128;
   localparam int NB   = VLEN / 8;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            in_valid = 1'b0;
   logic [1:0]      size_code = '0;
   logic [NB-1:0]   pred = '0;
   logic [VLEN-1:0] opa = '0;
   logic [VLEN-1:0] opb = '0;
   logic            out_valid;
   logic [VLEN-1:0] result;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vsplice_unit #(.VLEN(VLEN)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .size_code (size_code),
      .pred      (pred),
      .opa       (opa),
      .opb       (opb),
      .out_valid (out_valid),
      .result    (result)
   );

   function automatic logic [VLEN-1:0] rnd_vec();
      logic [VLEN-1:0] v;
      for (int k = 0; k < VLEN / 32; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   // Behavioural model, element by element (R1..R6)
   function automatic logic [VLEN-1:0] model(input logic [1:0] sz, input logic [NB-1:0] p,
                                             input logic [VLEN-1:0] a, input logic [VLEN-1:0] b);
      logic [VLEN-1:0] r;
      int eb, ne, lo, hi, x;
      eb = 1 << sz;
      ne = NB / eb;
      lo = -1;
      hi = -1;
      r  = '0;
      x  = 0;
      for (int e = 0; e < ne; e++) begin
         if (p[e*eb]) begin
            if (lo < 0) lo = e;
            hi = e;
         end
      end
      if (lo >= 0) begin
         for (int e = lo; e <= hi; e++) begin
            for (int k = 0; k < eb; k++) r[(x*eb+k)*8 +: 8] = a[(e*eb+k)*8 +: 8];
            x++;
         end
      end
      for (int e = 0; x < ne; e++) begin
         for (int k = 0; k < eb; k++) r[(x*eb+k)*8 +: 8] = b[(e*eb+k)*8 +: 8];
         x++;
      end
      return r;
   endfunction

   task automatic check_vec(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run(input string req, input logic [1:0] sz, input logic [NB-1:0] p);
      logic [VLEN-1:0] a, b, exp;
      a = rnd_vec();
      b = rnd_vec();
      exp = model(sz, p, a, b);
      @(negedge clk);
      in_valid  = 1'b1;
      size_code = sz;
      pred      = p;
      opa       = a;
      opb       = b;
      @(negedge clk);
      in_valid = 1'b0;
      checks++;
      if (out_valid !== 1'b1) begin
         errors++;
         $display("FAIL R7: out_valid actual %b expected 1", out_valid);
      end
      check_vec(req, result, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [VLEN-1:0] held;
      logic [NB-1:0] mid;
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || result !== '0) begin
         errors++;
         $display("FAIL R8: actual %b/%h expected 0/0", out_valid, result);
      end
      rst = 1'b0;

      for (int sz = 0; sz < 4; sz++) begin
         run("R5", 2'(sz), '0);
         run("R6", 2'(sz), '1);
         // single active bit: only aligned bits count (R1, R2)
         for (int i = 0; i < NB; i++) run((i % (1 << sz)) == 0 ? "R1" : "R2", 2'(sz), NB'(1) << i);
         // first and last with random gaps between them (R3, R4)
         for (int i = 0; i < NB; i++) begin
            for (int j = i; j < NB; j++) begin
               mid = NB'($urandom) & ((NB'(1) << j) - NB'(1)) & ~((NB'(2) << i) - NB'(1));
               run(j == NB - 1 ? "R4" : "R3", 2'(sz), (NB'(1) << i) | (NB'(1) << j) | mid);
            end
         end
         // only non-governing bits set: no element active (R2)
         if (sz != 0) run("R2", 2'(sz), {(NB/2){2'b10}});
         // hold while idle (R9)
         held = result;
         @(negedge clk);
         opa = rnd_vec();
         opb = rnd_vec();
         pred = '1;
         @(negedge clk);
         check_vec("R9", result, held);
         checks++;
         if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R7: idle out_valid actual %b expected 0", out_valid);
         end
      end

      // reset mid-stream clears state (R8)
      run("R3", 2'd0, 16'h0F0F);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check_vec("R8", result, '0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule